// File: doc/BRIEF.md
# Latency-Insensitive Relay Station Chain

This block is a chain of relay stations. It goes on a long point-to-point channel between two wrapped modules, so the wire can be split into clocked segments without changing what the consumer receives. Each link carries a data word and a blank flag. When the blank flag is set, the word means nothing and is ignored. A hold signal runs back against the data flow and tells the previous stage to keep presenting its current token.

Every station holds its hold output in a register. The stage in front of it therefore sees the hold one cycle late and may already have sent one more token. To absorb that token, each station keeps a main slot and an auxiliary slot. Its small controller has three states: empty, flowing and full. The number of stations is a parameter. The chain can be lengthened to any depth, and it neither loses, duplicates nor reorders the valid tokens. Each station adds one cycle of latency, like a pipeline register.

Top module: `lrs_chain`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dn_blank` is 1 and `up_hold` is 0.
- R2: A token is taken from upstream on a clock edge where `up_blank` is 0 and `up_hold` is 0. If `dn_hold` stays 0, `up_hold` never asserts, and once the chain is primed the downstream side receives one valid token every cycle.
- R3: A token is delivered downstream on a clock edge where `dn_blank` is 0 and `dn_hold` is 0. The delivered words are exactly the accepted words, in the same order.
- R4: A word presented with `up_blank` = 1 is never delivered, whatever its data field holds. Once the input goes idle, the count of delivered tokens equals the count of accepted tokens.
- R5: If `dn_blank` is 0 and `dn_hold` is 1 in a cycle, then in the next cycle `dn_blank` is still 0 and `dn_data` is unchanged.
- R6: Take an empty chain with `dn_hold` at 0. A token accepted at some edge appears on `dn_data` with `dn_blank` = 0 after exactly NUM_STAGES edges, counting the accepting edge as the first.
- R7: Each station stores at most two tokens. If `dn_hold` is held at 1 and the chain starts empty, the chain accepts exactly 2*NUM_STAGES tokens and then keeps `up_hold` at 1.
- R8: `up_hold` rises only in the cycle after the first station accepted a valid token, because it is a registered consequence of that acceptance.
- R9: When `dn_hold` falls on a full chain, the 2*NUM_STAGES stored tokens come out on consecutive cycles, with no bubble between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_data | input | DATA_W | Word offered by the upstream stage |
| up_blank | input | 1 | 1 when `up_data` carries no token |
| up_hold | output | 1 | Registered request that upstream keep its current token |
| dn_data | output | DATA_W | Word offered to the downstream stage |
| dn_blank | output | 1 | 1 when `dn_data` carries no token |
| dn_hold | input | 1 | Downstream request to keep the current output token |

## Verification
The bench builds the chain with DATA_W = 10 and NUM_STAGES = 3. Three stations are enough for backpressure to travel through two internal links with their one-cycle registered delay. The full-chain case of six stored tokens and the six-token drain can then be checked precisely. The 10-bit word lets the sequence pattern and the junk data on blank words differ in many bits, so a reordered, duplicated or leaked word shows up as a mismatch.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    // Occupancy of one station: nothing, main slot only, main and aux slots
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FLOW  = 2'd1,
        ST_FULL  = 2'd2
    } lrs_state_e;

    // Slot write controls produced by the station controller
    typedef struct packed {
        logic load_main;      // main slot takes the incoming word
        logic main_from_aux;  // main slot takes the aux word
        logic load_aux;       // aux slot takes the incoming word
    } lrs_ctl_t;

endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
    import lrs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  logic     dn_hold,
    output lrs_ctl_t ctl,
    output logic     main_full,
    output logic     up_hold
);

    typedef struct packed {
        lrs_state_e st;
        logic       hold;
    } ctrl_regs_t;

    ctrl_regs_t r_q;
    ctrl_regs_t r_d;
    lrs_ctl_t   ctl_d;

    always_comb begin
        r_d   = r_q;
        ctl_d = '0;
        unique case (r_q.st)
            ST_EMPTY: begin
                if (in_valid) begin
                    ctl_d.load_main = 1'b1;
                    r_d.st          = ST_FLOW;
                end
            end
            ST_FLOW: begin
                if (!dn_hold) begin
                    if (in_valid) begin
                        ctl_d.load_main = 1'b1;
                    end else begin
                        r_d.st = ST_EMPTY;
                    end
                end else if (in_valid) begin
                    // token still in flight because our hold is registered
                    ctl_d.load_aux = 1'b1;
                    r_d.st         = ST_FULL;
                end
            end
            ST_FULL: begin
                // upstream sees hold and keeps its word; input not taken
                if (!dn_hold) begin
                    ctl_d.main_from_aux = 1'b1;
                    r_d.st              = ST_FLOW;
                end
            end
            default: begin
                r_d.st = ST_EMPTY;
            end
        endcase
        r_d.hold = (r_d.st == ST_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_EMPTY;
            r_q.hold <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl       = ctl_d;
    assign main_full = (r_q.st != ST_EMPTY);
    assign up_hold   = r_q.hold;

endmodule

// File: rtl/lrs_store.sv
module lrs_store
    import lrs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lrs_ctl_t          ctl,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] main_data
);

    typedef struct packed {
        logic [DATA_W-1:0] main;
        logic [DATA_W-1:0] aux;
    } slots_t;

    slots_t s_q;
    slots_t s_d;

    always_comb begin
        s_d = s_q;
        if (ctl.load_main) begin
            s_d.main = in_data;
        end else if (ctl.main_from_aux) begin
            s_d.main = s_q.aux;
        end
        if (ctl.load_aux) begin
            s_d.aux = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign main_data = s_q.main;

endmodule

// File: rtl/lrs_station.sv
module lrs_station
    import lrs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_blank,
    output logic              up_hold,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_blank,
    input  logic              dn_hold
);

    lrs_ctl_t ctl;
    logic     main_full;

    lrs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (!up_blank),
        .dn_hold   (dn_hold),
        .ctl       (ctl),
        .main_full (main_full),
        .up_hold   (up_hold)
    );

    lrs_store #(
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .in_data   (up_data),
        .main_data (dn_data)
    );

    assign dn_blank = !main_full;

endmodule

// File: rtl/lrs_chain.sv
module lrs_chain #(
    parameter int DATA_W     = 16,
    parameter int NUM_STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] up_data,
    input  logic              up_blank,
    output logic              up_hold,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_blank,
    input  logic              dn_hold
);

    localparam int LINKS = NUM_STAGES + 1;

    logic [DATA_W-1:0] link_data  [LINKS];
    logic              link_blank [LINKS];
    logic              link_hold  [LINKS];

    assign link_data[0]          = up_data;
    assign link_blank[0]         = up_blank;
    assign link_hold[NUM_STAGES] = dn_hold;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        lrs_station #(
            .DATA_W (DATA_W)
        ) u_station (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_data  (link_data[g]),
            .up_blank (link_blank[g]),
            .up_hold  (link_hold[g]),
            .dn_data  (link_data[g+1]),
            .dn_blank (link_blank[g+1]),
            .dn_hold  (link_hold[g+1])
        );
    end

    assign up_hold  = link_hold[0];
    assign dn_data  = link_data[NUM_STAGES];
    assign dn_blank = link_blank[NUM_STAGES];

endmodule

// File: rtl/lrs_chain_chk.sv
module lrs_chain_chk #(
    parameter int DATA_W     = 16,
    parameter int NUM_STAGES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] up_data,
    input logic              up_blank,
    input logic              up_hold,
    input logic [DATA_W-1:0] dn_data,
    input logic              dn_blank,
    input logic              dn_hold
);

    localparam int CAP   = 2 * NUM_STAGES;
    localparam int OCC_W = $clog2(CAP + 1) + 1;

    logic [OCC_W-1:0] occ_q;
    logic             take_in;
    logic             give_out;
    logic             unused_up_data;

    assign take_in        = !up_blank && !up_hold;
    assign give_out       = !dn_blank && !dn_hold;
    assign unused_up_data = ^up_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(take_in) - OCC_W'(give_out);
        end
    end

    // R5
    out_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_hold && !dn_blank) |=> (!dn_blank && dn_data == $past(dn_data)));

    // R8
    hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_hold) |-> $past(!up_blank));

    // R7
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(CAP));

    // R4
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> dn_blank);

    // R7
    hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_hold |-> (occ_q >= OCC_W'(2)));

endmodule

bind lrs_chain lrs_chain_chk #(
    .DATA_W     (DATA_W),
    .NUM_STAGES (NUM_STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_data  (up_data),
    .up_blank (up_blank),
    .up_hold  (up_hold),
    .dn_data  (dn_data),
    .dn_blank (dn_blank),
    .dn_hold  (dn_hold)
);

// File: tb/lrs_chain_tb.sv
`timescale 1ns/1ps
module lrs_chain_tb;

    localparam int DW = 10;
    localparam int NS = 3;

    // row: [15:8] blank insertion per cycle, [7:0] downstream hold per cycle
    localparam logic [15:0] PATS [16] = '{
        16'h0000, 16'h00FF, 16'hFF00, 16'h5555,
        16'hAAAA, 16'h0F0F, 16'hF0F0, 16'h33CC,
        16'hCC33, 16'h0181, 16'h8001, 16'h00F0,
        16'h7E00, 16'h1248, 16'h6996, 16'h00FE
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] up_data;
    logic          up_blank;
    logic          up_hold;
    logic [DW-1:0] dn_data;
    logic          dn_blank;
    logic          dn_hold;

    int            checks = 0;
    int            errors = 0;
    int            send_idx = 0;
    int            recv_idx = 0;
    logic          hold_seen = 1'b0;
    logic          prev_held = 1'b0;
    logic [DW-1:0] prev_data = '0;
    logic          got = 1'b0;
    logic          done = 1'b0;

    always #2 clk = ~clk;

    lrs_chain #(
        .DATA_W     (DW),
        .NUM_STAGES (NS)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_data  (up_data),
        .up_blank (up_blank),
        .up_hold  (up_hold),
        .dn_data  (dn_data),
        .dn_blank (dn_blank),
        .dn_hold  (dn_hold)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock cycle of producer and consumer activity, driven at the falling edge
    task automatic cycle(input logic gap, input logic stall);
        logic acc;
        @(negedge clk);
        if (prev_held) begin
            chk(!dn_blank && dn_data == prev_data, "R5", int'(dn_data), int'(prev_data));
        end
        dn_hold = stall;
        got = 1'b0;
        if (!dn_blank && !dn_hold) begin
            chk(dn_data == pat(recv_idx), "R3", int'(dn_data), int'(pat(recv_idx)));
            recv_idx++;
            got = 1'b1;
        end
        prev_held = !dn_blank && dn_hold;
        prev_data = dn_data;
        acc = !up_blank && !hold_seen;
        if (acc) send_idx++;
        if (up_blank || acc) begin
            up_blank = gap;
            up_data  = gap ? DW'(send_idx * 11 + 3) : pat(send_idx);
        end
        hold_seen = up_hold;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        int cnt;
        int base;
        logic [15:0] lfsr;
        rst_n    = 1'b0;
        up_blank = 1'b1;
        up_data  = '0;
        dn_hold  = 1'b0;
        repeat (3) @(negedge clk);
        chk(dn_blank == 1'b1, "R1", int'(dn_blank), 1);
        chk(up_hold == 1'b0, "R1", int'(up_hold), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dn_blank == 1'b1, "R1", int'(dn_blank), 1);
        chk(up_hold == 1'b0, "R1", int'(up_hold), 0);

        // R6: first token latency through an empty chain
        cycle(1'b0, 1'b0);
        lat = 0;
        do begin
            cycle(1'b1, 1'b0);
            lat++;
        end while (!got && lat < 20);
        chk(lat == NS, "R6", lat, NS);

        // R2: free flow, no hold upstream, one token per cycle once primed
        for (int i = 0; i < 24; i++) begin
            cycle(1'b0, 1'b0);
            chk(up_hold == 1'b0, "R2", int'(up_hold), 0);
            if (i >= NS + 1) chk(got == 1'b1, "R2", int'(got), 1);
        end
        repeat (20) cycle(1'b1, 1'b0);
        chk(recv_idx == send_idx, "R4", recv_idx, send_idx);

        // R7: fill with downstream held
        base = send_idx;
        repeat (8 * NS) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        chk(send_idx - base == 2 * NS, "R7", send_idx - base, 2 * NS);
        chk(up_hold == 1'b1, "R7", int'(up_hold), 1);

        // R9: drain back to back
        cnt = 0;
        repeat (2 * NS) begin
            cycle(1'b1, 1'b0);
            if (got) cnt++;
        end
        chk(cnt == 2 * NS, "R9", cnt, 2 * NS);
        repeat (20) cycle(1'b1, 1'b0);
        chk(recv_idx == send_idx, "R4", recv_idx, send_idx);

        // table of blank and hold patterns
        for (int r = 0; r < 16; r++) begin
            for (int rep = 0; rep < 4; rep++) begin
                for (int b = 0; b < 8; b++) begin
                    cycle(PATS[r][8+b], PATS[r][b]);
                end
            end
        end

        // random blank and hold mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0] & lfsr[3], lfsr[5] | (lfsr[7] & lfsr[9]));
        end
        repeat (60) cycle(1'b1, 1'b0);
        // R4 and R3: everything accepted arrived, nothing extra
        chk(recv_idx == send_idx, "R4", recv_idx, send_idx);
        chk(dn_blank == 1'b1, "R4", int'(dn_blank), 1);
        chk(recv_idx > 500, "R3", recv_idx, 501);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule